// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Unit

This block watches a set of input pins, split into groups of eight, and raises one pending flag per group whenever an enabled pin in that group changes level. Each pin has its own enable bit in a per-group select register. A group's flag stays set until software clears it by writing a one to the clear register. Each flag drives an interrupt request, gated by an enable bit for that group. Detection does not depend on pin direction, so software can drive a pin it owns and raise a request on purpose.

Every pin value passes through a sampling path before change detection. First, a latch is transparent while the clock is low. Next, a rising-edge synchronizer register captures the latch output. Finally, a previous-value register holds the synchronizer's last value. A change is detected when the synchronized value differs from the previous value on a selected pin, and the group flag is set on the following edge.

Alongside this path, a combinational wake output per group compares each selected pin with its last synchronized value. This output works while the clock is stopped, so a pin change can wake the device.

Each group flag is a two-state machine with states FLG_IDLE and FLG_PEND. It has three transitions:
- SET: FLG_IDLE to FLG_PEND on a detected change.
- CLEAR: FLG_PEND to FLG_IDLE on a clear write with no change in the same cycle.
- HOLD: every other case keeps the current state.

Top module: `pin_change_unit`

## Requirements
- R1: After reset, all flags, interrupt outputs, select registers and group enables are zero.
- R2: A low-to-high change on a selected pin set up while the clock is low before rising edge k sets the group flag after edge k+1. The flag is still clear after edge k.
- R3: A high-to-low change on a selected pin sets its group flag with the same timing as R2.
- R4: A change on a pin whose select bit is zero sets no flag and raises no wake output. The select register for group g is at address g, and bit i selects pin 8*g+i.
- R5: A change sets only the flag of the group that contains the pin. Flag g is bit g of the flag outputs.
- R6: A flag stays set until a write to the clear register has a one in bit g. The clear register is at address NUM_GROUPS. Writing zero bits leaves the flags unchanged.
- R7: If a change sets a flag on the same edge as a clear write for that flag, the flag stays set.
- R8: The interrupt output for group g equals flag g AND bit g of the enable register. The enable register is at address NUM_GROUPS+1.
- R9: The wake output of group g is high, with no clock edge needed, whenever a selected pin differs from its last synchronized value.
- R10: Pins that already sit at nonzero levels during reset cause no flag after reset, even once they are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latch is transparent while low |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_GROUPS*8 | Watched pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 8 | Register write data |
| flags_o | output | NUM_GROUPS | Pending flag per group |
| irq_o | output | NUM_GROUPS | Interrupt request per group |
| wake_o | output | NUM_GROUPS | Combinational wake per group |

## Verification
The bench builds the unit with the default of four groups, which gives 32 pins. This is enough to show rising and falling changes landing in separate groups, without one group disturbing another. It covers a group with a partial select mask, and a flag that is set and cleared on the same edge. It also stops its own clock while low, so that the wake path can be observed with no edges, before detection resumes once the clock runs again.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int GROUP_W = 8;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pcg_sampler.sv
module pcg_sampler #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] pin_i,
    input  logic [GW-1:0] sel_i,
    output logic          set_o,
    output logic          wake_o
);
    logic [GW-1:0] lat_q;
    logic [GW-1:0] sync_q;
    logic [GW-1:0] prev_q;

    // Latch stage: transparent during the low clock phase.
    always_latch begin
        if (!clk) lat_q <= pin_i;
    end

    // Sync and previous copy run through reset as well, so they match on exit.
    always_ff @(posedge clk) begin
        sync_q <= lat_q;
        prev_q <= sync_q;
    end

    assign set_o  = |((sync_q ^ prev_q) & sel_i);
    assign wake_o = |((pin_i ^ sync_q) & sel_i);

    // R4
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |-> (!set_o && !wake_o));
endmodule

// File: rtl/pcg_flag.sv
module pcg_flag
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i) state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_PEND);
        irq_o  = flag_o && en_i;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pcg_regs.sv
module pcg_regs #(
    parameter int NG     = 4,
    parameter int GW     = 8,
    parameter int ADDR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [GW-1:0]    wr_data_i,
    output logic [NG*GW-1:0] sel_o,
    output logic [NG-1:0]    en_o,
    output logic [NG-1:0]    clr_o
);
    localparam int CLR_ADDR = NG;
    localparam int EN_ADDR  = NG + 1;

    for (genvar g = 0; g < NG; g++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_o[g*GW +: GW] <= '0;
            else if (wr_en_i && wr_addr_i == ADDR_W'(g))
                sel_o[g*GW +: GW] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_en_i && wr_addr_i == ADDR_W'(EN_ADDR))
            en_o <= wr_data_i[NG-1:0];
    end

    assign clr_o = (wr_en_i && wr_addr_i == ADDR_W'(CLR_ADDR)) ? wr_data_i[NG-1:0] : '0;

    // R8
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(EN_ADDR)) |=> (en_o == $past(wr_data_i[NG-1:0])));
endmodule

// File: rtl/pin_change_unit.sv
module pin_change_unit #(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = $clog2(NUM_GROUPS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS*8-1:0] pins_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [7:0]            wr_data_i,
    output logic [NUM_GROUPS-1:0] flags_o,
    output logic [NUM_GROUPS-1:0] irq_o,
    output logic [NUM_GROUPS-1:0] wake_o
);
    import pcg_pkg::*;
    localparam int NPINS = NUM_GROUPS * GROUP_W;

    logic [NPINS-1:0]      sel;
    logic [NUM_GROUPS-1:0] en;
    logic [NUM_GROUPS-1:0] clr;
    logic [NUM_GROUPS-1:0] setp;

    pcg_regs #(.NG(NUM_GROUPS), .GW(GROUP_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .sel_o(sel), .en_o(en), .clr_o(clr)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pcg_sampler #(.GW(GROUP_W)) u_smp (
            .clk(clk), .rst_n(rst_n),
            .pin_i(pins_i[g*GROUP_W +: GROUP_W]),
            .sel_i(sel[g*GROUP_W +: GROUP_W]),
            .set_o(setp[g]), .wake_o(wake_o[g])
        );
        pcg_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(setp[g]), .clr_i(clr[g]),
            .en_i(en[g]), .flag_o(flags_o[g]), .irq_o(irq_o[g])
        );
    end

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~flags_o) == '0));
    // R5
    group_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~$past(flags_o)) & ~$past(setp)) == '0);
endmodule

// File: tb/tb_pin_change_unit.sv
module tb_pin_change_unit;
    localparam int NG = 4;
    localparam int AW = $clog2(NG + 2);

    logic          clk = 1'b0;
    logic          run = 1'b1;
    logic          rst_n = 1'b0;
    logic [NG*8-1:0] pins = 32'hA53C0FF0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NG-1:0] flags, irq, wake;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pin_change_unit #(.NUM_GROUPS(NG)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .flags_o(flags), .irq_o(irq), .wake_o(wake)
    );

    always begin
        #4;
        if (run) clk = ~clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic toggle_and_wait(input int pin);
        @(negedge clk);
        pins[pin] = ~pins[pin];
        @(posedge clk); @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 flags", 32'(flags), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 wake", 32'(wake), 0);
        for (int g = 0; g < NG; g++) wr(g, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 no false flag", 32'(flags), 0);
    endtask

    task automatic t_rise();
        @(negedge clk);
        pins[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 not yet after edge k", 32'(flags), 0);
        @(posedge clk); @(negedge clk);
        check("R2 set after edge k+1", 32'(flags), 32'h1);
    endtask

    task automatic t_fall();
        toggle_and_wait(8);
        check("R3 falling sets group1 / R5 only group1 added", 32'(flags), 32'h3);
    endtask

    task automatic t_mask();
        wr(2, 8'hFE);
        @(negedge clk);
        pins[16] = ~pins[16];
        #1;
        check("R4 no wake on unselected", 32'(wake), 0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R4 unselected pin ignored", 32'(flags), 32'h3);
    endtask

    task automatic t_sticky();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 flags held", 32'(flags), 32'h3);
        wr(NG, 8'h00);
        check("R6 zero clear no effect", 32'(flags), 32'h3);
        wr(NG, 8'h03);
        check("R6 clear by one", 32'(flags), 0);
    endtask

    task automatic t_setwins();
        toggle_and_wait(24);
        check("R5 group3 only", 32'(flags), 32'h8);
        @(negedge clk);
        pins[25] = ~pins[25];
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(NG); wr_data = 8'h08;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 set wins over clear", 32'(flags), 32'h8);
    endtask

    task automatic t_irq();
        check("R8 no irq while disabled", 32'(irq), 0);
        wr(NG + 1, 8'h08);
        check("R8 irq follows enabled flag", 32'(irq), 32'h8);
        wr(NG + 1, 8'h07);
        check("R8 irq off when group disabled", 32'(irq), 0);
        wr(NG + 1, 8'h0F);
        wr(NG, 8'h08);
        check("R8 irq off after clear", 32'(irq), 0);
    endtask

    task automatic t_wake();
        @(negedge clk);
        run = 1'b0;
        #20;
        pins[5] = ~pins[5];
        #3;
        check("R9 wake without clock", 32'(wake), 32'h1);
        check("R9 no flag while stopped", 32'(flags), 0);
        run = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 flag after clock resumes", 32'(flags), 32'h1);
        check("R9 wake drops once synced", 32'(wake), 0);
        check("R8 irq on resume", 32'(irq), 32'h1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_mask();
        t_sticky();
        t_setwins();
        t_irq();
        t_wake();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule